// File: doc/BRIEF.md
# Recurrence Sweep Phase Generator

This block is the phase engine of a digitally synthesised frequency sweep. A phase accumulator is advanced every sample clock by an increment word. That increment is itself rewritten on every sample by a recurrence, so the output frequency moves smoothly along the sweep and never steps. Three sweep shapes are available. A linear sweep adds a fixed change to the increment. A quadratic sweep adds a change that itself grows by a fixed amount each sample. An exponential sweep scales the increment by a constant of the form (1 + x) on every sample, which gives an instantaneous frequency of F1·k^t.

A single start pulse captures the start increment, the rate word, the profile and the sample count. It clears the phase and the difference state, and a fixed number of updates follows. When the last update is done the increment stays where it ended and a one-cycle completion pulse is raised. All increment arithmetic is exact wide fixed-point integer arithmetic. The increment carries fraction bits below the phase LSB, so slow sweeps do not drift. The sine lookup and the computation of the rate constants sit outside the block.

Top module: `sweep_phase_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `phase`, `inc_out`, `busy` and `done` become zero.
- R2: A clock edge with `start` high loads `inc_out` with `start_inc`, clears the phase accumulator and the quadratic difference register to zero, captures `profile_sel`, `rate_cfg` and `sample_count`, and sets `busy`. This applies even when a sweep is already running.
- R3: On every edge without `start`, busy or idle, the 64-bit phase accumulator adds the integer part `inc_out[95:32]`, modulo 2^64. `phase` is bits 63:32 of the accumulator.
- R4: Linear profile (`profile_sel` = 2'b00): on each busy update the increment becomes increment + rate, modulo 2^96.
- R5: Quadratic profile (2'b01): on each busy update the increment adds the difference register, and the difference register (zero at start) then adds the rate. This gives inc(n) = inc(0) + rate·n·(n−1)/2, modulo 2^96.
- R6: Exponential profile (2'b10): with x = `rate_cfg[31:0]` read as a fraction x/2^32, each busy update adds floor(increment·x / 2^32) to the increment. The product is truncated toward zero, and x = 0 holds the increment constant.
- R7: The reserved profile code 2'b11 leaves the increment unchanged on every update.
- R8: A sweep performs max(`sample_count`, 1) updates. On the edge of the last update `busy` falls and `done` is high for exactly one cycle. `done` is never high together with `busy`.
- R9: When no sweep is running, `inc_out` holds its value until the next start.
- R10: Changes to `profile_sel`, `rate_cfg`, `start_inc` and `sample_count` while `start` is low have no effect on a running sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that starts or restarts a sweep |
| profile_sel | input | 2 | Sweep shape: 00 linear, 01 quadratic, 10 exponential, 11 hold |
| start_inc | input | 96 | Start increment, 64 integer bits over 32 fraction bits |
| rate_cfg | input | 96 | Rate word: added change (linear, quadratic) or x in the low 32 bits (exponential) |
| sample_count | input | 32 | Number of updates in the sweep |
| phase | output | 32 | Top 32 bits of the phase accumulator |
| inc_out | output | 96 | Current increment word |
| busy | output | 1 | High while a sweep is running |
| done | output | 1 | One-cycle pulse after the final update |

## Verification
Two situations are hard to reach from the ports. The first is an exponential update whose product falls below one LSB, so that truncation decides the result. The second is a restart or a change of configuration that arrives in the middle of a sweep. The stimulus reaches the first with a minimal x applied to a small increment. It reaches the second by pulsing start again partway through a long linear sweep, and by changing every configuration input during a quadratic sweep. A behavioural model in the bench replays the recurrences with wide integers and compares phase, increment, busy and done on every clock. Separate checks confirm that the sweep length follows the captured count and not the changed input.

// File: rtl/sweep_pkg.sv
// Shared types for the sweep phase generator.
// Assumes: a 2-bit profile code, which is also the encoding at the top ports.
package sweep_pkg;
    typedef enum logic [1:0] {
        PROF_LIN  = 2'b00,
        PROF_QUAD = 2'b01,
        PROF_EXP  = 2'b10,
        PROF_HOLD = 2'b11
    } profile_e;
endpackage

// File: rtl/sweep_ctrl.sv
// Sweep sequencer: counts the updates of one sweep and produces busy and the
// one-cycle done pulse. A count of zero is treated as one.
// Assumes: start has priority over every other event.
module sweep_ctrl #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count_in,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W:0]   cnt_nx;
    logic             last;
    logic             busy_q;
    logic             done_q;

    // next count, and whether this update is the final one
    always_comb begin
        cnt_nx = {1'b0, cnt_q} + 1'b1;
        last   = (cnt_nx >= {1'b0, count_q});
    end

    // sequencer state: load on start, count while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            count_q <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else if (start) begin
            cnt_q   <= '0;
            count_q <= count_in;
            busy_q  <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                cnt_q <= cnt_nx[CNT_W-1:0];
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (count_q == '0 || cnt_q < count_q));
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy_q);
endmodule

// File: rtl/sweep_inc_unit.sv
// Increment recurrence: holds the wide increment word and rewrites it on each
// busy update according to the captured profile (linear, quadratic through a
// cascaded difference register, or exponential through a (1+x) multiply).
// Assumes: X_W <= IW; all sums wrap modulo 2^IW.
module sweep_inc_unit
    import sweep_pkg::*;
#(
    parameter int IW  = 96,
    parameter int X_W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [1:0]    prof_in,
    input  logic [IW-1:0] start_inc,
    input  logic [IW-1:0] rate_in,
    output logic [IW-1:0] inc
);
    localparam int PW = IW + X_W;

    profile_e      prof_q;
    logic [IW-1:0] rate_q;
    logic [IW-1:0] inc_q;
    logic [IW-1:0] diff_q;
    logic [PW-1:0] prod;
    logic [IW-1:0] frac_step;
    logic [IW-1:0] inc_nx;
    logic [IW-1:0] diff_nx;

    // next increment and difference for the captured profile
    always_comb begin
        prod      = {{X_W{1'b0}}, inc_q} * {{IW{1'b0}}, rate_q[X_W-1:0]};
        frac_step = IW'(prod >> X_W);
        inc_nx    = inc_q;
        diff_nx   = diff_q;
        unique case (prof_q)
            PROF_LIN:  inc_nx = inc_q + rate_q;
            PROF_QUAD: begin
                inc_nx  = inc_q + diff_q;
                diff_nx = diff_q + rate_q;
            end
            PROF_EXP:  inc_nx = inc_q + frac_step;
            PROF_HOLD: inc_nx = inc_q;
        endcase
    end

    // recurrence registers: load on start, advance on step, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prof_q <= PROF_LIN;
            rate_q <= '0;
            inc_q  <= '0;
            diff_q <= '0;
        end else if (load) begin
            prof_q <= profile_e'(prof_in);
            rate_q <= rate_in;
            inc_q  <= start_inc;
            diff_q <= '0;
        end else if (step) begin
            inc_q  <= inc_nx;
            diff_q <= diff_nx;
        end
    end

    assign inc = inc_q;

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(inc_q));
    a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (inc_q == $past(start_inc) && diff_q == '0));
    a_r4_lin_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && prof_q == PROF_LIN) |=> (inc_q == $past(inc_q) + $past(rate_q)));
    a_r6_exp_no_shrink: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && prof_q == PROF_EXP && !inc_q[IW-1]) |=> (inc_q >= $past(inc_q)));
    a_r7_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && prof_q == PROF_HOLD) |=> $stable(inc_q));
endmodule

// File: rtl/sweep_phase_acc.sv
// Phase accumulator: adds the integer part of the increment on every clock and
// clears on a sweep start.
// Assumes: the caller supplies the integer part of the increment already sliced.
module sweep_phase_acc #(
    parameter int ACC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [ACC_W-1:0] inc_int,
    output logic [ACC_W-1:0] acc
);
    logic [ACC_W-1:0] acc_q;

    // accumulate every clock, clear on start
    always_ff @(posedge clk) begin
        if (!rst_n)   acc_q <= '0;
        else if (clr) acc_q <= '0;
        else          acc_q <= acc_q + inc_int;
    end

    assign acc = acc_q;

    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));
    a_r3_zero_inc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc_int == '0) |=> $stable(acc_q));
endmodule

// File: rtl/sweep_phase_gen.sv
// Top of the recurrence sweep phase generator: sequencer, increment recurrence
// and phase accumulator. The phase output is the top PH_W accumulator bits.
// Assumes: PH_W <= ACC_W; FRAC_W may be zero (no sub-LSB increment bits).
module sweep_phase_gen #(
    parameter  int ACC_W  = 64,
    parameter  int FRAC_W = 32,
    parameter  int X_W    = 32,
    parameter  int CNT_W  = 32,
    parameter  int PH_W   = 32,
    localparam int IW     = ACC_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       profile_sel,
    input  logic [IW-1:0]    start_inc,
    input  logic [IW-1:0]    rate_cfg,
    input  logic [CNT_W-1:0] sample_count,
    output logic [PH_W-1:0]  phase,
    output logic [IW-1:0]    inc_out,
    output logic             busy,
    output logic             done
);
    logic [IW-1:0]    inc_w;
    logic [ACC_W-1:0] inc_int;
    logic [ACC_W-1:0] acc_w;
    logic             busy_w;

    sweep_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .count_in (sample_count),
        .busy     (busy_w),
        .done     (done)
    );

    sweep_inc_unit #(.IW(IW), .X_W(X_W)) u_inc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .step      (busy_w),
        .prof_in   (profile_sel),
        .start_inc (start_inc),
        .rate_in   (rate_cfg),
        .inc       (inc_w)
    );

    generate
        if (FRAC_W > 0) begin : g_frac
            assign inc_int = inc_w[IW-1:FRAC_W];
        end else begin : g_nofrac
            assign inc_int = inc_w;
        end
    endgenerate

    sweep_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start),
        .inc_int (inc_int),
        .acc     (acc_w)
    );

    assign phase   = acc_w[ACC_W-1 -: PH_W];
    assign inc_out = inc_w;
    assign busy    = busy_w;
endmodule

// File: tb/sweep_phase_gen_test.sv
// Bench: behavioural reference of the sweep recurrences, compared every clock.
module sweep_phase_gen_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   profile_sel = 2'b00;
    logic [95:0]  start_inc = '0;
    logic [95:0]  rate_cfg = '0;
    logic [31:0]  sample_count = '0;
    logic [31:0]  phase;
    logic [95:0]  inc_out;
    logic         busy;
    logic         done;

    int checks = 0;
    int fails  = 0;
    bit chk_en = 1'b0;
    bit finished = 1'b0;

    // reference state
    logic [63:0]  m_acc = '0;
    logic [95:0]  m_inc = '0, m_diff = '0, m_rate = '0;
    logic [1:0]   m_prof = 2'b00;
    longint       m_cnt = 0, m_count = 0;
    bit           m_busy = 0, m_done = 0;
    string        m_tag = "R1";

    always #2.5 clk = ~clk;

    sweep_phase_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .profile_sel(profile_sel),
        .start_inc(start_inc), .rate_cfg(rate_cfg), .sample_count(sample_count),
        .phase(phase), .inc_out(inc_out), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model, evaluated on each rising edge
    always @(posedge clk) begin
        logic [127:0] p;
        if (!rst_n) begin
            m_acc = '0; m_inc = '0; m_diff = '0; m_busy = 0; m_done = 0;
            m_cnt = 0; m_tag = "R1";
        end else if (start) begin
            m_acc = '0; m_inc = start_inc; m_diff = '0; m_busy = 1; m_done = 0;
            m_cnt = 0; m_prof = profile_sel; m_rate = rate_cfg;
            m_count = longint'(sample_count); m_tag = "R2";
        end else begin
            m_acc  = m_acc + m_inc[95:32];
            m_done = 0;
            if (m_busy) begin
                case (m_prof)
                    2'b00: begin m_inc = m_inc + m_rate; m_tag = "R4"; end
                    2'b01: begin m_inc = m_inc + m_diff; m_diff = m_diff + m_rate; m_tag = "R5"; end
                    2'b10: begin
                        p = {32'd0, m_inc} * {96'd0, m_rate[31:0]};
                        m_inc = m_inc + p[127:32];
                        m_tag = "R6";
                    end
                    default: m_tag = "R7";
                endcase
                m_cnt++;
                if (m_cnt >= m_count) begin m_busy = 0; m_done = 1; end
            end else m_tag = "R9";
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (chk_en && !finished) begin
            chk(phase == m_acc[63:32], "R3", {64'd0, phase}, {64'd0, m_acc[63:32]});
            chk(inc_out == m_inc, m_tag, inc_out, m_inc);
            chk(busy == m_busy, "R8", {95'd0, busy}, {95'd0, m_busy});
            chk(done == m_done, "R8", {95'd0, done}, {95'd0, m_done});
        end
    end

    task automatic do_start(input logic [1:0] pr, input logic [95:0] si,
                            input logic [95:0] rt, input logic [31:0] n);
        @(negedge clk);
        profile_sel = pr; start_inc = si; rate_cfg = rt; sample_count = n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_until_done(input int lim, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!done && n < lim);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        int n;
        logic [95:0] held;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(phase == 0 && inc_out == 0 && !busy && !done, "R1",
            {busy, done, inc_out[63:0], phase[29:0]}, '0);
        rst_n = 1'b1;
        chk_en = 1'b1;

        // R4 linear sweep, then R9 hold
        do_start(2'b00, {64'h0000_0123_4567_89AB, 32'h8000_0000}, {64'h0000_0000_0100_0000, 32'h4000_0000}, 20);
        chk(inc_out == {64'h0000_0123_4567_89AB, 32'h8000_0000} && phase == 0 && busy, "R2", inc_out, {64'h0000_0123_4567_89AB, 32'h8000_0000});
        run_until_done(100, n);
        chk(n == 20, "R8", 96'(n), 96'd20);
        held = inc_out;
        repeat (5) @(negedge clk);
        chk(inc_out == held, "R9", inc_out, held);

        // R5 quadratic sweep
        do_start(2'b01, {64'h0000_0001_0000_0000, 32'd0}, {64'h0000_0000_0010_0000, 32'h1234_5678}, 30);
        run_until_done(100, n);
        chk(n == 30, "R8", 96'(n), 96'd30);
        // inc(30) = inc0 + rate*30*29/2
        chk(inc_out == {64'h0000_0001_0000_0000, 32'd0} + 96'd435 * {64'h0000_0000_0010_0000, 32'h1234_5678},
            "R5", inc_out, {64'h0000_0001_0000_0000, 32'd0} + 96'd435 * {64'h0000_0000_0010_0000, 32'h1234_5678});

        // R6 exponential sweep, x = 0.5
        do_start(2'b10, {64'h0000_0001_0000_0000, 32'd0}, {64'd0, 32'h8000_0000}, 40);
        run_until_done(100, n);
        // R6 truncation with a minimal fraction
        do_start(2'b10, {64'd5, 32'd7}, {64'hFFFF, 32'd1}, 8);
        @(negedge clk);
        chk(inc_out == {64'd5, 32'd12}, "R6", inc_out, {64'd5, 32'd12});
        run_until_done(100, n);
        // R6 x = 0 holds the increment
        do_start(2'b10, {64'h0000_0002_0000_0000, 32'd9}, {64'd77, 32'd0}, 6);
        run_until_done(100, n);
        chk(inc_out == {64'h0000_0002_0000_0000, 32'd9}, "R6", inc_out, {64'h0000_0002_0000_0000, 32'd9});

        // R7 reserved code
        do_start(2'b11, {64'h0000_0003_0000_0000, 32'd1}, {64'd1, 32'd1}, 10);
        run_until_done(100, n);
        chk(inc_out == {64'h0000_0003_0000_0000, 32'd1}, "R7", inc_out, {64'h0000_0003_0000_0000, 32'd1});

        // R8 count of zero acts as one
        do_start(2'b00, {64'h0000_0004_0000_0000, 32'd0}, {64'd1, 32'd0}, 0);
        chk(busy && !done, "R8", {94'd0, busy, done}, 96'd2);
        @(negedge clk);
        chk(!busy && done, "R8", {94'd0, busy, done}, 96'd1);
        @(negedge clk);
        chk(!done, "R8", {95'd0, done}, 96'd0);

        // R2 restart in the middle of a sweep, with wrap of the increment
        do_start(2'b00, {96{1'b1}} - 96'd20, 96'd7, 50);
        repeat (9) @(negedge clk);
        do_start(2'b10, {64'h0000_0000_8000_0000, 32'd0}, {64'd0, 32'h0100_0000}, 12);
        chk(inc_out == {64'h0000_0000_8000_0000, 32'd0} && phase == 0, "R2", inc_out, {64'h0000_0000_8000_0000, 32'd0});
        run_until_done(100, n);
        chk(n == 12, "R2", 96'(n), 96'd12);

        // R10 configuration changes during a sweep are ignored
        do_start(2'b01, {64'h0000_0005_0000_0000, 32'd0}, {64'h100, 32'd3}, 20);
        repeat (3) @(negedge clk);
        profile_sel = 2'b10; rate_cfg = {64'hDEAD, 32'hFFFF_FFFF};
        start_inc = '1; sample_count = 5;
        run_until_done(100, n);
        chk(n == 17, "R10", 96'(n), 96'd17);
        chk(inc_out == {64'h0000_0005_0000_0000, 32'd0} + 96'd190 * {64'h100, 32'd3}, "R10",
            inc_out, {64'h0000_0005_0000_0000, 32'd0} + 96'd190 * {64'h100, 32'd3});

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule